// File: doc/BRIEF.md
# Integer ALU with overflow trap

A purely combinational 32-bit integer execution unit for the execute stage of a load-store RISC pipeline. The decoder gives it a 4-bit operation code, two register operands, a 16-bit instruction immediate with a flag that puts the immediate in place of the second operand, and a 5-bit instruction shift amount with a flag that takes the amount from a register instead. In the same cycle it returns a 32-bit result, an overflow flag, and a write-back kill.

The unit covers trapping and non-trapping add and subtract, the four bitwise operations, signed and unsigned set-less-than, three shifts, and the upper-immediate constant. How the immediate is extended depends on the operation. Bitwise operations zero-fill the upper half. Arithmetic and compare operations copy the immediate's sign bit into the upper half. On a trapping overflow the result is still driven, and the kill output tells the pipeline to leave the destination register unchanged.

Top module: `alu_int_exec`

## Requirements
- R1: Op codes: 0 ADD and 2 SUB give the 32-bit two's-complement sum or difference of a and the second operand. They raise overflow when the signed result does not fit in 32 bits.
- R2: Op codes 1 ADDU and 3 SUBU give the same modulo-2^32 result as ADD and SUB but never raise overflow.
- R3: Op codes 4 AND, 5 OR, 6 XOR and 7 NOR give the bitwise function. NOR is the complement of OR. None of them raises overflow.
- R4: Op code 8 SLT compares a and the second operand as two's-complement numbers. Op code 9 SLTU compares them as unsigned numbers. The result is 1 when a is smaller and 0 otherwise, with bits 31:1 always zero and no overflow.
- R5: When imm_sel_i is 1, the second operand is the 16-bit immediate. It is zero-extended for ops 4 to 7 and sign-extended for ops 0 to 3, 8 and 9.
- R6: Op code 13 LUI returns the immediate in bits 31:16 with zeros in bits 15:0, whatever a and b are, and never raises overflow.
- R7: Op codes 10 SLL, 11 SRL and 12 SRA shift a. SRA fills the vacated bits with copies of a[31]. The amount is shamt_i when shamt_reg_i is 0. When shamt_reg_i is 1 it is b_i[4:0], and b_i[31:5] are ignored. Shifts never raise overflow.
- R8: wb_kill_o equals ovf_o in every case. The result is still driven when overflow is flagged.
- R9: Op codes 14 and 15 are undefined. They give a zero result with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First register operand, also the shifted value |
| b_i | input | 32 | Second register operand, also the register shift amount |
| imm_i | input | 16 | Instruction immediate |
| imm_sel_i | input | 1 | Use the extended immediate as the second operand |
| shamt_i | input | 5 | Instruction shift amount |
| shamt_reg_i | input | 1 | Take the shift amount from b_i[4:0] |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of a trapping add or subtract |
| wb_kill_o | output | 1 | Suppress write-back of the result |

## Verification
The bench drives the operand pairs at the boundary values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF through every operation. A unit with a wrong overflow equation would either miss the trap at the positive and negative limits or raise it on the unsigned forms. An unsigned compare that is wired as a signed one would put 0x80000000 and 0xFFFFFFFF below zero. Immediates with bit 15 set expose a unit that extends them the wrong way for bitwise or arithmetic use. Register shift amounts with random upper bits expose a shifter that does not mask the amount to five bits, and negative operands expose an arithmetic shift that fills with zeros.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_LUI  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             imm_sel_i,
  input  logic             zext_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic             shamt_reg_i,
  output logic [XLEN-1:0]  opnd_o,
  output logic [SHW-1:0]   amt_o
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;
  logic            fill;

  assign fill    = zext_i ? 1'b0 : imm_i[IMM_W-1];
  assign imm_ext = {{EXT_W{fill}}, imm_i};
  assign opnd_o  = imm_sel_i ? imm_ext : b_i;
  // register amount: low bits only
  assign amt_o   = shamt_reg_i ? b_i[SHW-1:0] : shamt_i;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            sovf_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  logic [XLEN-1:0] b_inv;
  logic [XLEN:0]   full;
  logic            sa, sb, sr;

  assign b_inv = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_inv} + {{XLEN{1'b0}}, sub_i};
  assign sum_o = full[XLEN-1:0];

  assign sa = a_i[XLEN-1];
  assign sb = b_inv[XLEN-1];
  assign sr = full[XLEN-1];

  assign sovf_o = (sa == sb) && (sr != sa);
  // valid when sub_i: compare derived from the difference
  assign lt_s_o = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : sr;
  assign lt_u_o = ~full[XLEN];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] stg [SHW+1];
  logic            fill;

  function automatic logic [XLEN-1:0] bit_rev(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  assign src    = left_i ? bit_rev(a_i) : a_i;
  assign fill   = arith_i & ~left_i & a_i[XLEN-1];
  assign stg[0] = src;

  // log2 barrel, right shifting; left uses reversal
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{D{fill}}, stg[s][XLEN-1:D]} : stg[s];
  end

  assign res_o = left_i ? bit_rev(stg[SHW]) : stg[SHW];
endmodule

// File: rtl/alu_int_exec.sv
module alu_int_exec
  import alu_int_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int SHW  = $clog2(XLEN)
) (
  input  logic [3:0]       op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             imm_sel_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic             shamt_reg_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ovf_o,
  output logic             wb_kill_o
);
  alu_op_e         op;
  logic            is_logic, is_sub, trap_op;
  logic [XLEN-1:0] opnd;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] sum, shres;
  logic            sovf, lt_s, lt_u;

  assign op       = alu_op_e'(op_i);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  assign trap_op  = (op == OP_ADD) || (op == OP_SUB);

  alu_opnd_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .b_i         (b_i),
    .imm_i       (imm_i),
    .imm_sel_i   (imm_sel_i),
    .zext_i      (is_logic),
    .shamt_i     (shamt_i),
    .shamt_reg_i (shamt_reg_i),
    .opnd_o      (opnd),
    .amt_o       (amt)
  );

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i    (a_i),
    .b_i    (opnd),
    .sub_i  (is_sub),
    .sum_o  (sum),
    .sovf_o (sovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_shifter #(.XLEN(XLEN)) u_shift (
    .a_i     (a_i),
    .amt_i   (amt),
    .left_i  (op == OP_SLL),
    .arith_i (op == OP_SRA),
    .res_o   (shres)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
      OP_AND:  result_o = a_i & opnd;
      OP_OR:   result_o = a_i | opnd;
      OP_XOR:  result_o = a_i ^ opnd;
      OP_NOR:  result_o = ~(a_i | opnd);
      OP_SLT:  result_o = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA: result_o = shres;
      OP_LUI:  result_o = {imm_i, {(XLEN-IMM_W){1'b0}}};
      default: result_o = '0;
    endcase
  end

  assign ovf_o     = trap_op & sovf;
  assign wb_kill_o = ovf_o;

  always_comb begin
    if ((op == OP_ADDU) || (op == OP_SUBU))
      assert_unsigned_no_ovf_R2: assert (!ovf_o);
    if (is_logic || (op == OP_SLT) || (op == OP_SLTU))
      assert_logic_cmp_no_ovf_R3: assert (!ovf_o);
    if ((op == OP_SLT) || (op == OP_SLTU))
      assert_slt_boolean_R4: assert (result_o[XLEN-1:1] == '0);
    if (op == OP_LUI)
      assert_lui_low_zero_R6: assert (result_o[XLEN-IMM_W-1:0] == '0 && !ovf_o);
    if (op == OP_SRA)
      assert_sra_keeps_sign_R7: assert (result_o[XLEN-1] == a_i[XLEN-1]);
    if ((op == OP_RSV0) || (op == OP_RSV1))
      assert_undef_quiet_R9: assert (result_o == '0 && !ovf_o);
  end
endmodule

// File: tb/alu_int_exec_tb_top.sv
module alu_int_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        imm_sel, shamt_reg;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        ovf, kill;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_int_exec dut_i (
    .op_i        (op),
    .a_i         (a),
    .b_i         (b),
    .imm_i       (imm),
    .imm_sel_i   (imm_sel),
    .shamt_i     (shamt),
    .shamt_reg_i (shamt_reg),
    .result_o    (result),
    .ovf_o       (ovf),
    .wb_kill_o   (kill)
  );

  function automatic string tag_of(input int o, input bit isel);
    if (isel && (o <= 9)) return "R5";
    case (o)
      0, 2:        return "R1";
      1, 3:        return "R2";
      4, 5, 6, 7:  return "R3";
      8, 9:        return "R4";
      10, 11, 12:  return "R7";
      13:          return "R6";
      default:     return "R9";
    endcase
  endfunction

  task automatic model(input int o, input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] im, input bit isel, input logic [4:0] sa,
                       input bit sreg, output logic [31:0] r, output bit v);
    logic [31:0] q;
    int          n;
    longint      s;
    q = y;
    if (isel) q = (o >= 4 && o <= 7) ? {16'h0, im} : {{16{im[15]}}, im};
    n = sreg ? int'(y[4:0]) : int'(sa);
    v = 0;
    r = 0;
    case (o)
      0, 1: begin
        s = longint'($signed(x)) + longint'($signed(q));
        r = x + q;
        v = (o == 0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      2, 3: begin
        s = longint'($signed(x)) - longint'($signed(q));
        r = x - q;
        v = (o == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      4:  r = x & q;
      5:  r = x | q;
      6:  r = x ^ q;
      7:  r = ~(x | q);
      8:  r = ($signed(x) < $signed(q)) ? 32'd1 : 32'd0;
      9:  r = (x < q) ? 32'd1 : 32'd0;
      10: r = x << n;
      11: r = x >> n;
      12: r = $unsigned($signed(x) >>> n);
      13: r = {im, 16'h0};
      default: r = 0;
    endcase
  endtask

  task automatic apply(input int o, input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] im, input bit isel, input logic [4:0] sa,
                       input bit sreg);
    logic [31:0] er;
    bit          ev;
    @(posedge clk);
    op = 4'(o); a = x; b = y; imm = im; imm_sel = isel; shamt = sa; shamt_reg = sreg;
    model(o, x, y, im, isel, sa, sreg, er, ev);
    @(negedge clk);
    n_chk++;
    if (result !== er || ovf !== ev) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h: result=%h ovf=%b expected result=%h ovf=%b",
               tag_of(o, isel), o, x, y, im, result, ovf, er, ev);
    end
    n_chk++;
    if (kill !== ev) begin  // R8
      n_bad++;
      $display("FAIL R8 op=%0d: wb_kill=%b expected %b", o, kill, ev);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] corner [8];
    corner = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
               32'h8000_0001, 32'h0000_FFFF, 32'h1234_5678};
    op = 0; a = 0; b = 0; imm = 0; imm_sel = 0; shamt = 0; shamt_reg = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state check: idle zero inputs give a zero sum (R1)
    @(negedge clk);
    n_chk++;
    if (result !== 32'h0 || ovf !== 1'b0 || kill !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle: result=%h ovf=%b expected 00000000 0", result, ovf);
    end
    // corner operand pairs through every op (R1..R4, R7, R9)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(o, corner[i], corner[j], 16'h8001, 1'b0, 5'(i * 4 + j), j[0]);
    // immediates with both sign states (R5, R6)
    for (int o = 0; o < 14; o++)
      for (int i = 0; i < 8; i++) begin
        apply(o, corner[i], 32'hDEAD_BEEF, 16'h8000, 1'b1, 5'd31, 1'b0);
        apply(o, corner[i], 32'hDEAD_BEEF, 16'h7FFF, 1'b1, 5'd0, 1'b0);
        apply(o, corner[i], 32'h0, 16'hFFFF, 1'b1, 5'd16, 1'b0);
      end
    // register shift amounts with junk upper bits (R7)
    for (int i = 0; i < 64; i++)
      for (int o = 10; o < 13; o++)
        apply(o, $urandom | 32'h8000_0000, {$urandom} | 32'hFFFF_FFE0 & {27'h7FFFFFF, 5'(i)},
              16'h0, 1'b0, 5'(~i), 1'b1);
    // random sweep (all requirements)
    for (int k = 0; k < 3000; k++)
      apply(int'($urandom_range(0, 15)), $urandom, $urandom, 16'($urandom),
            1'($urandom), 5'($urandom), 1'($urandom));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule